// File: doc/BRIEF.md
# Ethernet destination address filter

This block decides, for each incoming frame, whether the receive path should keep it. It looks at the six destination address bytes, the frame length without the frame check sequence, and a small set of receive mode bits. It answers with an accept flag and a class tag: plain, multicast or broadcast. A 16-entry table of 48-bit station addresses, each with its own enable bit, supplies the exact-match part of the decision.

Software or a loader engine fills the table through a 16-bit write port, one address word at a time, and writes the enable mask as a separate word. While the controller is held in its reset mode, any entry can be read back as three 16-bit words. The checks are made in a fixed order and the first one that applies gives the answer. The result is registered and comes out as a one-cycle pulse in the clock after the frame strobe.

Top module: `dst_addr_filter`

## Requirements
- R1: A high `frm_valid` in one clock cycle makes `res_valid` high for exactly the next cycle. While `res_valid` is low, `res_accept` is 0 and `res_class` is 0.
- R2: A frame whose `frm_len` is below 60 is accepted with class plain (0) when mode bit 14 (accept short frames) is set, and rejected when it is clear. No other check affects such a frame.
- R3: With mode bit 12 (promiscuous) set, a frame of length 60 or more whose first destination byte has bit 0 clear is accepted with class plain (0).
- R4: With mode bit 11 (all multicast) set, a frame of length 60 or more whose first destination byte has bit 0 set is accepted with class multicast (1). This check comes before the broadcast check, so the all-ones address gets class 1 here.
- R5: With mode bit 13 (broadcast) set, a frame of length 60 or more whose destination is all ones, and that no earlier check has taken, is accepted with class broadcast (2).
- R6: Any other frame of length 60 or more is accepted with class plain (0) only if its destination equals a table entry whose enable bit is set. Otherwise it is rejected.
- R7: A pulse on `tbl_wr` with `tbl_sel` k (0 to 2) writes `tbl_wdata` into address word k of entry `tbl_idx`. Word k holds destination bytes 2k (low half) and 2k+1 (high half). Byte 0 is `frm_dst[7:0]`, the first byte on the wire. With `tbl_sel` = 3, `tbl_wdata` bit i becomes the enable bit of entry i, and `tbl_idx` is ignored.
- R8: While `rd_in_reset` is high, `rd_w0`, `rd_w1` and `rd_w2` show address words 0, 1 and 2 of the entry chosen by `rd_ptr`. While it is low, all three are 0.
- R9: Reset (`rst_n` low at a clock edge) clears every mode bit, every enable bit and every table entry. After reset, short frames and broadcast frames are therefore rejected.
- R10: A pulse on `mode_wr` loads the mode bits from `mode_wdata` bits 14, 13, 12 and 11. The other bits are ignored. Frames use the mode held before the edge on which they are strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Load mode bits |
| mode_wdata | input | 16 | Mode word (bits 14,13,12,11 used) |
| tbl_wr | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Entry index for address word writes |
| tbl_sel | input | 2 | Address word 0..2, or 3 for enable mask |
| tbl_wdata | input | 16 | Table write data |
| rd_in_reset | input | 1 | Controller is in reset mode; allows readback |
| rd_ptr | input | 4 | Entry pointer for readback |
| rd_w0 | output | 16 | Bytes 1:0 of the selected entry |
| rd_w1 | output | 16 | Bytes 3:2 of the selected entry |
| rd_w2 | output | 16 | Bytes 5:4 of the selected entry |
| frm_valid | input | 1 | Frame header strobe |
| frm_dst | input | 48 | Destination address, byte 0 in bits 7:0 |
| frm_len | input | 16 | Frame length excluding FCS |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_class | output | 2 | 0 plain, 1 multicast, 2 broadcast |

## Verification
The assertions assume that `frm_dst` and `frm_len` hold known values whenever `frm_valid` is high. They judge each frame against the mode bits held in the cycle of the strobe, so a mode write in that same cycle is allowed. The stimulus changes every input on the falling edge and never leaves a frame field unknown. It writes the mode and the table only between frames, so the bench's own model, which is updated after each write, always matches the state the design holds.

// File: rtl/dafilt_pkg.sv
// Shared types for the destination address filter.
// Assumes a 48-bit destination address split into three 16-bit words.
package dafilt_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_MCAST = 2'd1,
        CLS_BCAST = 2'd2
    } frame_class_e;

    // bit positions of the mode bits inside the mode word
    localparam int MODE_RUNT_BIT  = 14;
    localparam int MODE_BCAST_BIT = 13;
    localparam int MODE_PROMI_BIT = 12;
    localparam int MODE_ALLMC_BIT = 11;

    typedef struct packed {
        logic runt;
        logic bcast;
        logic promisc;
        logic allmc;
    } mode_t;

    localparam int ADDR_W   = 48;
    localparam int WORD_W   = 16;
    localparam int ADDR_WDS = ADDR_W / WORD_W;

endpackage

// File: rtl/dafilt_table.sv
// Address table: ENTRIES x 48-bit entries, each with an enable bit.
// Written one 16-bit word at a time; word select 3 loads the enable mask.
// Produces an any-enabled-entry-matches flag and a gated readback word.
// Assumes ENTRIES is a power of two and not above 16.
module dafilt_table
    import dafilt_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [1:0]          wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   probe,
    output logic                hit,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [ADDR_W-1:0]   rd_entry,
    output logic [ENTRIES-1:0]  en_mask
);

    logic [ADDR_W-1:0]  ent_q [ENTRIES];
    logic [ENTRIES-1:0] en_q;
    logic [ENTRIES-1:0] match_vec;
    logic               sel_mask;

    assign sel_mask = (wr_sel == 2'd3);

    // enable mask register, loaded by word select 3
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && sel_mask)
            en_q <= wr_data[ENTRIES-1:0];
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // one entry: stores the addressed 16-bit word on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (wr_en && !sel_mask && (wr_idx == IDX_W'(g)))
                ent_q[g][wr_sel*WORD_W +: WORD_W] <= wr_data;
        end
        // exact compare of this enabled entry against the probe
        assign match_vec[g] = en_q[g] && (ent_q[g] == probe);
    end

    assign hit      = |match_vec;
    assign en_mask  = en_q;
    // readback gated by the reset-mode qualifier
    assign rd_entry = rd_en ? ent_q[rd_idx] : '0;

endmodule

// File: rtl/dafilt_decide.sv
// Priority decision for one frame: short-frame, promiscuous, all-multicast,
// broadcast, then table match. Purely combinational.
// Assumes hit already reflects only enabled table entries.
module dafilt_decide
    import dafilt_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input  mode_t              mode,
    input  logic [ADDR_W-1:0]  dst,
    input  logic [LEN_W-1:0]   len,
    input  logic               hit,
    output logic               accept,
    output frame_class_e       cls
);

    logic is_short;
    logic is_group;
    logic is_bcast;

    assign is_short = (len < LEN_W'(MIN_LEN));
    assign is_group = dst[0];
    assign is_bcast = &dst;

    // first matching check in the fixed order gives the answer
    always_comb begin
        accept = 1'b0;
        cls    = CLS_PLAIN;
        if (is_short) begin
            accept = mode.runt;
        end else if (mode.promisc && !is_group) begin
            accept = 1'b1;
        end else if (mode.allmc && is_group) begin
            accept = 1'b1;
            cls    = CLS_MCAST;
        end else if (mode.bcast && is_bcast) begin
            accept = 1'b1;
            cls    = CLS_BCAST;
        end else begin
            accept = hit;
        end
    end

endmodule

// File: rtl/dst_addr_filter.sv
// Destination address filter top. Holds the mode bits, the address table
// and the registered result. Result appears one clock after frm_valid.
// Assumes frame fields are stable and known while frm_valid is high.
module dst_addr_filter
    import dafilt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic [15:0]        mode_wdata,
    input  logic               tbl_wr,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [1:0]         tbl_sel,
    input  logic [15:0]        tbl_wdata,
    input  logic               rd_in_reset,
    input  logic [IDX_W-1:0]   rd_ptr,
    output logic [15:0]        rd_w0,
    output logic [15:0]        rd_w1,
    output logic [15:0]        rd_w2,
    input  logic               frm_valid,
    input  logic [47:0]        frm_dst,
    input  logic [LEN_W-1:0]   frm_len,
    output logic               res_valid,
    output logic               res_accept,
    output logic [1:0]         res_class
);

    mode_t              mode_q;
    logic               hit;
    logic               dec_accept;
    frame_class_e       dec_cls;
    logic [ADDR_W-1:0]  rd_entry;
    logic [ENTRIES-1:0] en_mask;
    logic               unused_mode;

    assign unused_mode = ^{mode_wdata[15], mode_wdata[10:0], en_mask};

    // mode bit register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= '{runt:    mode_wdata[MODE_RUNT_BIT],
                        bcast:   mode_wdata[MODE_BCAST_BIT],
                        promisc: mode_wdata[MODE_PROMI_BIT],
                        allmc:   mode_wdata[MODE_ALLMC_BIT]};
    end

    dafilt_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (tbl_idx),
        .wr_sel   (tbl_sel),
        .wr_data  (tbl_wdata),
        .probe    (frm_dst),
        .hit      (hit),
        .rd_en    (rd_in_reset),
        .rd_idx   (rd_ptr),
        .rd_entry (rd_entry),
        .en_mask  (en_mask)
    );

    dafilt_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
        .mode   (mode_q),
        .dst    (frm_dst),
        .len    (frm_len),
        .hit    (hit),
        .accept (dec_accept),
        .cls    (dec_cls)
    );

    // split the readback entry into its three words
    assign rd_w0 = rd_entry[0*WORD_W +: WORD_W];
    assign rd_w1 = rd_entry[1*WORD_W +: WORD_W];
    assign rd_w2 = rd_entry[2*WORD_W +: WORD_W];

    // result register: one-cycle pulse, zero outputs when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_class  <= CLS_PLAIN;
        end else begin
            res_valid  <= frm_valid;
            res_accept <= frm_valid && dec_accept;
            res_class  <= frm_valid ? dec_cls : CLS_PLAIN;
        end
    end

endmodule

// File: rtl/dafilt_chk.sv
// Property checker for the destination address filter, bound to the top.
// Assumes frame fields are known while frm_valid is high.
module dafilt_chk
    import dafilt_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input logic              clk,
    input logic              rst_n,
    input mode_t             mode_q,
    input logic [15:0]       mask_q,
    input logic              rd_in_reset,
    input logic [15:0]       rd_w0,
    input logic [15:0]       rd_w1,
    input logic [15:0]       rd_w2,
    input logic              frm_valid,
    input logic [47:0]       frm_dst,
    input logic [LEN_W-1:0]  frm_len,
    input logic              res_valid,
    input logic              res_accept,
    input logic [1:0]        res_class
);

    logic short_f;
    assign short_f = (frm_len < LEN_W'(MIN_LEN));

    assert_res_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);
    assert_res_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_accept && res_class == 2'd0));
    assert_short_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && short_f && !mode_q.runt) |=> !res_accept);
    assert_short_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && short_f && mode_q.runt) |=> (res_accept && res_class == 2'd0));
    assert_promisc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !short_f && mode_q.promisc && !frm_dst[0]) |=>
        (res_accept && res_class == 2'd0));
    assert_mcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !short_f && mode_q.allmc && frm_dst[0]) |=>
        (res_accept && res_class == 2'd1));
    assert_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !short_f && mode_q.bcast && !mode_q.allmc && (&frm_dst)) |=>
        (res_accept && res_class == 2'd2));
    assert_rd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_in_reset |-> (rd_w0 == 16'd0 && rd_w1 == 16'd0 && rd_w2 == 16'd0));
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == 16'd0 && mode_q == '0));

endmodule

bind dst_addr_filter dafilt_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .mask_q      (16'(en_mask)),
    .rd_in_reset (rd_in_reset),
    .rd_w0       (rd_w0),
    .rd_w1       (rd_w1),
    .rd_w2       (rd_w2),
    .frm_valid   (frm_valid),
    .frm_dst     (frm_dst),
    .frm_len     (frm_len),
    .res_valid   (res_valid),
    .res_accept  (res_accept),
    .res_class   (res_class)
);

// File: tb/dst_addr_filter_tb.sv
// Self-checking bench: directed corner cases plus seeded random frames,
// compared against a bench-side model of the requirements.
module dst_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic        tbl_wr = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [1:0]  tbl_sel = '0;
    logic [15:0] tbl_wdata = '0;
    logic        rd_in_reset = 1'b0;
    logic [3:0]  rd_ptr = '0;
    logic [15:0] rd_w0, rd_w1, rd_w2;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dst = '0;
    logic [15:0] frm_len = '0;
    logic        res_valid, res_accept;
    logic [1:0]  res_class;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [15:0] M_RUNT  = 16'h4000;
    localparam logic [15:0] M_BCAST = 16'h2000;
    localparam logic [15:0] M_PROMI = 16'h1000;
    localparam logic [15:0] M_ALLMC = 16'h0800;

    logic [47:0] tb_ent [16];
    logic [15:0] tb_mask = '0;
    logic [15:0] tb_mode = '0;

    always #2 clk = ~clk;

    dst_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
        .rd_in_reset(rd_in_reset), .rd_ptr(rd_ptr),
        .rd_w0(rd_w0), .rd_w1(rd_w1), .rd_w2(rd_w2),
        .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_len(frm_len),
        .res_valid(res_valid), .res_accept(res_accept), .res_class(res_class)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected {accept, class} from the requirement rules
    function automatic logic [2:0] exp_res(logic [47:0] d, int len);
        if (len < 60) return {tb_mode[14], 2'd0};
        if (tb_mode[12] && !d[0]) return 3'b100;
        if (tb_mode[11] && d[0]) return 3'b101;
        if (tb_mode[13] && d == '1) return 3'b110;
        for (int i = 0; i < 16; i++)
            if (tb_mask[i] && tb_ent[i] == d) return 3'b100;
        return 3'b000;
    endfunction

    task automatic set_mode(logic [15:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
        tb_mode = v & (M_RUNT | M_BCAST | M_PROMI | M_ALLMC);
    endtask

    task automatic tbl_write(int idx, int sel, logic [15:0] v);
        tbl_wr = 1'b1; tbl_idx = 4'(idx); tbl_sel = 2'(sel); tbl_wdata = v;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (sel == 3) tb_mask = v;
        else tb_ent[idx][sel*16 +: 16] = v;
    endtask

    task automatic send(string req, logic [47:0] d, int len);
        logic [2:0] e;
        e = exp_res(d, len);
        frm_valid = 1'b1; frm_dst = d; frm_len = 16'(len);
        @(negedge clk);
        frm_valid = 1'b0;
        check({req, " valid"}, 64'(res_valid), 64'd1);
        check({req, " result"}, {61'd0, res_accept, res_class}, 64'(e));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] d;
        logic [15:0] ms;
        for (int i = 0; i < 16; i++) tb_ent[i] = '0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(res_valid), 64'd0);
        check("R1 reset class", {62'd0, res_class}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: after reset table reads zero, short and broadcast frames rejected
        rd_in_reset = 1'b1; rd_ptr = 4'd5;
        #1 check("R9 entry cleared", {16'd0, rd_w2, rd_w1, rd_w0}, 64'd0);
        send("R9 bcast rejected", '1, 64);
        send("R9 short rejected", 48'h0000_1234_5678, 30);

        // R10: only bits 14..11 are kept; garbage elsewhere has no effect
        set_mode(16'h87FF);
        send("R10 ignored bits", '1, 64);
        check("R10 ignored bits accept", 64'(res_accept), 64'd0);

        // R7: load the table
        for (int i = 0; i < 16; i++) begin
            d = {$urandom, $urandom};
            if (i % 2 == 0) d[0] = 1'b0; else d[0] = 1'b1;
            for (int k = 0; k < 3; k++) tbl_write(i, k, d[k*16 +: 16]);
        end
        tbl_write(0, 3, 16'hA5F3);

        // R7/R8: readback in reset mode, zeros otherwise
        for (int i = 0; i < 16; i++) begin
            rd_ptr = 4'(i);
            #1 check("R7 R8 readback", {16'd0, rd_w2, rd_w1, rd_w0}, {16'd0, tb_ent[i]});
        end
        rd_in_reset = 1'b0;
        #1 check("R8 gated zero", {16'd0, rd_w2, rd_w1, rd_w0}, 64'd0);
        @(negedge clk);

        // R2: short frame accepted only with the short-frame bit
        set_mode(M_RUNT);
        send("R2 short accepted", 48'h0102_0304_0506, 59);
        set_mode(16'h0000);
        send("R2 short enabled match still rejected", tb_ent[0], 59);
        check("R2 no further checks", 64'(res_accept), 64'd0);

        // R6: boundary length, enabled and disabled entries
        send("R6 len 60 enabled match", tb_ent[0], 60);
        check("R6 accept", 64'(res_accept), 64'd1);
        send("R6 disabled entry", tb_ent[2], 64);
        check("R6 disabled reject", 64'(res_accept), 64'd0);
        send("R6 no match", 48'h0000_0000_0002, 64);

        // R4/R5: broadcast under both modes
        set_mode(M_BCAST | M_ALLMC);
        send("R4 bcast tagged multicast", '1, 64);
        check("R4 class", {62'd0, res_class}, 64'd1);
        set_mode(M_BCAST);
        send("R5 bcast", '1, 100);
        check("R5 class", {62'd0, res_class}, 64'd2);
        send("R5 group not bcast", 48'h0000_0000_0103, 64);

        // R3: promiscuous takes unicast only
        set_mode(M_PROMI);
        send("R3 unicast", 48'h7777_6666_5544, 64);
        send("R3 group rejected", 48'h7777_6666_5545, 64);
        @(negedge clk);
        check("R1 single pulse", 64'(res_valid), 64'd0);

        // random frames
        for (int n = 0; n < 600; n++) begin
            int r, len;
            if (n % 25 == 0) begin
                ms = 16'($urandom);
                set_mode(ms);
            end
            if (n % 150 == 75) tbl_write(0, 3, 16'($urandom));
            r = int'($urandom % 4);
            case (r)
                0: d = tb_ent[$urandom % 16];
                1: d = '1;
                2: d = {$urandom, $urandom};
                default: begin d = {$urandom, $urandom}; d[0] = 1'b1; end
            endcase
            len = 50 + int'($urandom % 20);
            send("R2 R3 R4 R5 R6 random", d, len);
            if ($urandom % 3 == 0) begin
                @(negedge clk);
                check("R1 idle", {61'd0, res_valid, res_accept, res_class[0]}, 64'd0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule